// File: doc/BRIEF.md
# Decode-stage branch resolver

This block produces the next fetch address for a five-stage in-order pipeline. It also holds the fetch/decode pipeline register. It resolves conditional branches during decode instead of waiting for the memory stage. A dedicated adder in decode always forms a candidate target: the latched sequential address plus the sign-extended 16-bit offset. A zero test on the first source register's read value decides whether a branch is taken. The fetch-side select then picks either the sequential address or that target in the same cycle.

When a branch resolves taken, the word fetched alongside it is on the wrong path. It is replaced by an all-zero word in the fetch/decode register, so a taken branch costs one lost cycle. Branches never need the execute, memory or write-back stages. The register file sits outside the block: the block presents the source index, and the read value comes back combinationally. Forwarding into the zero test is not part of this block.

Top module: `dbr_nextpc`

## Requirements
- R1: While `rst` is high at a clock edge, the fetch address, the latched instruction and the latched sequential address all become `RESET_PC` (the instruction becomes all zeros), and `flush_fetch` is 0.
- R2: When no redirect occurs, `next_pc` equals `fetch_pc + 4` modulo 2^XLEN, and `fetch_pc` takes that value at the next edge.
- R3: Instruction bits use big-endian numbering (bit 0 is the MSB). `id_target` always equals `ifid_npc` plus the offset in bits 16..31 (`ifid_ir[15:0]`), sign-extended from bit 16 (`ifid_ir[15]`). It is computed for every latched word, branch or not.
- R4: Opcode 6'h04 in bits 0..5 (`ifid_ir[31:26]`) is branch-if-zero: it redirects exactly when `rs_value` is zero.
- R5: Opcode 6'h05 is branch-if-nonzero: it redirects exactly when `rs_value` is nonzero.
- R6: Any other opcode, including the all-zero word, never redirects, whatever `rs_value` and the offset are.
- R7: On a redirect, `flush_fetch` is 1 and `next_pc` equals `id_target`. At the next edge `fetch_pc` becomes that target and the latched instruction becomes all zeros: a one-cycle penalty.
- R8: Without a redirect, the fetched word `imem_rdata` is latched into `ifid_ir` and `fetch_pc + 4` into `ifid_npc` at the edge.
- R9: `rs_index` presents bits 6..10 (`ifid_ir[25:21]`) and `rt_index` presents bits 11..15 (`ifid_ir[20:16]`) of the latched instruction.
- R10: Target addition and sequential increment both wrap modulo 2^XLEN, so a negative offset from a low address reaches the top of the address space, and sequential fetch wraps back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_rdata | input | 32 | Instruction word fetched at `fetch_pc` |
| rs_value | input | XLEN | Register-file read value for `rs_index` |
| fetch_pc | output | XLEN | Address being fetched this cycle |
| next_pc | output | XLEN | Address to fetch in the next cycle |
| ifid_ir | output | 32 | Latched instruction in decode |
| ifid_npc | output | XLEN | Latched sequential address of that instruction |
| rs_index | output | 5 | Condition register index sent to the register file |
| rt_index | output | 5 | Second source index sent to the register file |
| id_target | output | XLEN | Candidate branch target formed in decode |
| flush_fetch | output | 1 | Redirect taken; the word fetched this cycle is squashed |

## Verification
The bench aims at the offset sign boundary. An offset of 0x8000 must move backwards by 32768 and 0x7FFF forwards. A design that extends from the wrong bit, or that numbers the fields little-endian, gives a wrong `id_target` or reads the wrong index. Each of the two branch opcodes is tested in both polarities. Non-branch opcodes are tested with a zero register value, which would satisfy branch-if-zero, and with a nonzero value, which would satisfy branch-if-nonzero. A decoder that lets the condition through without a branch opcode would redirect in one of these cases. After every taken branch the bench looks for the squashed word and a one-cycle penalty, and it follows a backward branch from address 4 through the wrap to address 0.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

    localparam int INSN_W = 32;
    localparam int OPC_W  = 6;
    localparam int RIDX_W = 5;
    localparam int IMM_W  = 16;

    // big-endian field starts (bit 0 = MSB)
    localparam int OPC_BE_LO  = 0;
    localparam int RS_BE_LO   = 6;
    localparam int RT_BE_LO   = 11;
    localparam int IMM_BE_LO  = 16;

    localparam logic [OPC_W-1:0] OPC_BRZ  = 6'h04;
    localparam logic [OPC_W-1:0] OPC_BRNZ = 6'h05;

    localparam logic [INSN_W-1:0] SQUASH_WORD = '0;

    typedef enum logic [1:0] {
        BK_NONE = 2'd0,
        BK_EQZ  = 2'd1,
        BK_NEZ  = 2'd2
    } br_kind_e;

    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic [IMM_W-1:0]  imm;
    } insn_fields_t;

    // little-endian index of the LSB of a big-endian field
    function automatic int le_lsb(input int be_lo, input int width);
        return INSN_W - be_lo - width;
    endfunction

    function automatic br_kind_e classify(input logic [OPC_W-1:0] opc);
        br_kind_e k;
        case (opc)
            OPC_BRZ:  k = BK_EQZ;
            OPC_BRNZ: k = BK_NEZ;
            default:  k = BK_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/dbr_field_split.sv
module dbr_field_split
    import dbr_pkg::*;
(
    input  logic [INSN_W-1:0] ir,
    output insn_fields_t      fields,
    output br_kind_e          kind
);
    localparam int OPC_LSB = le_lsb(OPC_BE_LO, OPC_W);
    localparam int RS_LSB  = le_lsb(RS_BE_LO, RIDX_W);
    localparam int RT_LSB  = le_lsb(RT_BE_LO, RIDX_W);
    localparam int IMM_LSB = le_lsb(IMM_BE_LO, IMM_W);

    always_comb begin
        fields.opc = ir[OPC_LSB +: OPC_W];
        fields.rs  = ir[RS_LSB  +: RIDX_W];
        fields.rt  = ir[RT_LSB  +: RIDX_W];
        fields.imm = ir[IMM_LSB +: IMM_W];
        kind       = classify(fields.opc);
    end
endmodule

// File: rtl/dbr_target_add.sv
module dbr_target_add
    import dbr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]  base,
    input  logic [IMM_W-1:0] offset,
    output logic [XLEN-1:0]  target
);
    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] offset_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            assign offset_ext = {{EXT_W{offset[IMM_W-1]}}, offset};
        end else begin : g_trunc
            assign offset_ext = offset[XLEN-1:0];
        end
    endgenerate

    assign target = base + offset_ext;
endmodule

// File: rtl/dbr_zero_test.sv
module dbr_zero_test
    import dbr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  br_kind_e        kind,
    input  logic [XLEN-1:0] value,
    output logic            take
);
    logic is_zero;

    assign is_zero = (value == '0);

    always_comb begin
        unique case (kind)
            BK_EQZ:  take = is_zero;
            BK_NEZ:  take = !is_zero;
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/dbr_nextpc.sv
module dbr_nextpc
    import dbr_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [INSN_W-1:0]    imem_rdata,
    input  logic [XLEN-1:0]      rs_value,
    output logic [XLEN-1:0]      fetch_pc,
    output logic [XLEN-1:0]      next_pc,
    output logic [INSN_W-1:0]    ifid_ir,
    output logic [XLEN-1:0]      ifid_npc,
    output logic [RIDX_W-1:0]    rs_index,
    output logic [RIDX_W-1:0]    rt_index,
    output logic [XLEN-1:0]      id_target,
    output logic                 flush_fetch
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    typedef struct packed {
        logic [INSN_W-1:0] ir;
        logic [XLEN-1:0]   npc;
    } ifid_t;

    logic [XLEN-1:0] pc_q;
    ifid_t           ifid_q, ifid_d;
    logic [XLEN-1:0] seq_pc;
    insn_fields_t    fld;
    br_kind_e        kind;
    logic            take;

    // decode side
    dbr_field_split u_split (
        .ir     (ifid_q.ir),
        .fields (fld),
        .kind   (kind)
    );

    dbr_target_add #(.XLEN(XLEN)) u_tadd (
        .base   (ifid_q.npc),
        .offset (fld.imm),
        .target (id_target)
    );

    dbr_zero_test #(.XLEN(XLEN)) u_ztest (
        .kind  (kind),
        .value (rs_value),
        .take  (take)
    );

    // fetch side select
    assign seq_pc  = pc_q + STEP;
    assign next_pc = take ? id_target : seq_pc;

    always_comb begin
        if (take) begin
            ifid_d.ir  = SQUASH_WORD;
            ifid_d.npc = seq_pc;
        end else begin
            ifid_d.ir  = imem_rdata;
            ifid_d.npc = seq_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q       <= RESET_PC;
            ifid_q.ir  <= SQUASH_WORD;
            ifid_q.npc <= RESET_PC;
        end else begin
            pc_q   <= next_pc;
            ifid_q <= ifid_d;
        end
    end

    assign fetch_pc    = pc_q;
    assign ifid_ir     = ifid_q.ir;
    assign ifid_npc    = ifid_q.npc;
    assign rs_index    = fld.rs;
    assign rt_index    = fld.rt;
    assign flush_fetch = take;
endmodule

// File: rtl/dbr_nextpc_chk.sv
module dbr_nextpc_chk
    import dbr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [INSN_W-1:0] imem_rdata,
    input logic [XLEN-1:0]   rs_value,
    input logic [XLEN-1:0]   fetch_pc,
    input logic [XLEN-1:0]   next_pc,
    input logic [INSN_W-1:0] ifid_ir,
    input logic [XLEN-1:0]   ifid_npc,
    input logic [XLEN-1:0]   id_target,
    input logic              flush_fetch
);
    logic [OPC_W-1:0] opc;
    assign opc = ifid_ir[INSN_W-1 -: OPC_W];

    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        !flush_fetch |=> fetch_pc == $past(fetch_pc) + XLEN'(4)); // R2

    AST_REDIRECT_PC: assert property (@(posedge clk) disable iff (rst)
        flush_fetch |=> fetch_pc == $past(id_target)); // R7

    AST_SQUASH_WORD: assert property (@(posedge clk) disable iff (rst)
        flush_fetch |=> ifid_ir == '0); // R7

    AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        !flush_fetch |=> (ifid_ir == $past(imem_rdata)) && (ifid_npc == $past(fetch_pc) + XLEN'(4))); // R8

    AST_BRZ_COND: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_BRZ) |-> flush_fetch == (rs_value == '0)); // R4

    AST_BRNZ_COND: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_BRNZ) |-> flush_fetch == (rs_value != '0)); // R5

    AST_NONBR_QUIET: assert property (@(posedge clk) disable iff (rst)
        (opc != OPC_BRZ && opc != OPC_BRNZ) |-> !flush_fetch); // R6

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> !flush_fetch && ifid_ir == '0); // R1

    AST_NEXT_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (next_pc != id_target) |-> !flush_fetch); // R7
endmodule

bind dbr_nextpc dbr_nextpc_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .imem_rdata  (imem_rdata),
    .rs_value    (rs_value),
    .fetch_pc    (fetch_pc),
    .next_pc     (next_pc),
    .ifid_ir     (ifid_ir),
    .ifid_npc    (ifid_npc),
    .id_target   (id_target),
    .flush_fetch (flush_fetch)
);

// File: tb/dbr_nextpc_bench.sv
module dbr_nextpc_bench;
    localparam int NV = 9;
    localparam logic [31:0] FILL = 32'h0C00_1234;

    // instruction, register value, expected redirect
    localparam logic [31:0] VEC_IR [NV] = '{
        32'h1060_0010, 32'h1060_0010, 32'h14E0_FFF0, 32'h14E0_0008, 32'h2000_0040,
        32'h1BE2_0000, 32'h1020_8000, 32'h1440_7FFF, 32'h0000_0000 };
    localparam logic [31:0] VEC_RS [NV] = '{
        32'h0, 32'h5, 32'h1, 32'h0, 32'h0,
        32'h1, 32'h0, 32'h8000_0000, 32'h0 };
    localparam logic VEC_TK [NV] = '{
        1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0 };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_rdata = '0;
    logic [31:0] rs_value = '0;
    logic [31:0] fetch_pc, next_pc, ifid_ir, ifid_npc, id_target;
    logic [4:0]  rs_index, rt_index;
    logic        flush_fetch;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int cyc = 0;

    dbr_nextpc u_dbr_nextpc (
        .clk(clk), .rst(rst), .imem_rdata(imem_rdata), .rs_value(rs_value),
        .fetch_pc(fetch_pc), .next_pc(next_pc), .ifid_ir(ifid_ir), .ifid_npc(ifid_npc),
        .rs_index(rs_index), .rt_index(rt_index), .id_target(id_target),
        .flush_fetch(flush_fetch)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<5000", cyc);
            finish_run();
        end
    end

    function automatic logic [31:0] sext16(input logic [31:0] w);
        return {{16{w[15]}}, w[15:0]};
    endfunction

    initial begin
        logic [31:0] exp_pc, exp_npc, exp_tgt;

        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1 fetch_pc", fetch_pc, 32'h0);
        chk("R1 ifid_ir", ifid_ir, 32'h0);
        chk("R1 ifid_npc", ifid_npc, 32'h0);
        chk("R1 flush", {31'b0, flush_fetch}, 32'h0);
        rst = 1'b0;
        exp_pc = 32'h0;

        for (int i = 0; i < NV; i++) begin
            imem_rdata = VEC_IR[i];
            rs_value   = '0;
            @(posedge clk);
            exp_pc  = exp_pc + 32'd4;
            exp_npc = exp_pc;
            @(negedge clk);
            imem_rdata = FILL;
            rs_value   = VEC_RS[i];
            #1;
            exp_tgt = exp_npc + sext16(VEC_IR[i]);
            chk($sformatf("R8 ifid_ir v%0d", i), ifid_ir, VEC_IR[i]);
            chk($sformatf("R8 ifid_npc v%0d", i), ifid_npc, exp_npc);
            chk($sformatf("R9 rs_index v%0d", i), {27'b0, rs_index}, {27'b0, VEC_IR[i][25:21]});
            chk($sformatf("R9 rt_index v%0d", i), {27'b0, rt_index}, {27'b0, VEC_IR[i][20:16]});
            chk($sformatf("R3 id_target v%0d", i), id_target, exp_tgt);
            // R4 R5 R6: redirect decision per opcode and value
            chk($sformatf("R4/R5/R6 flush v%0d", i), {31'b0, flush_fetch}, {31'b0, VEC_TK[i]});
            chk($sformatf("R7/R2 next_pc v%0d", i), next_pc,
                VEC_TK[i] ? exp_tgt : exp_pc + 32'd4);
            @(posedge clk);
            exp_pc = VEC_TK[i] ? exp_tgt : exp_pc + 32'd4;
            @(negedge clk);
            #1;
            chk($sformatf("R2/R7 fetch_pc v%0d", i), fetch_pc, exp_pc);
            chk($sformatf("R7/R8 squash v%0d", i), ifid_ir, VEC_TK[i] ? 32'h0 : FILL);
        end

        // mid-run reset
        rst = 1'b1;
        imem_rdata = 32'h1000_0000;
        @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1 mid fetch_pc", fetch_pc, 32'h0);
        chk("R1 mid ifid_ir", ifid_ir, 32'h0);
        chk("R1 mid flush", {31'b0, flush_fetch}, 32'h0);
        rst = 1'b0;

        // R10: backward branch from address 4 wraps to the top, then back to 0
        imem_rdata = 32'h1420_FFF0;
        rs_value   = '0;
        @(posedge clk);
        @(negedge clk);
        imem_rdata = FILL;
        rs_value   = 32'h1;
        #1;
        chk("R10 target wrap", id_target, 32'hFFFF_FFF4);
        chk("R7 wrap flush", {31'b0, flush_fetch}, 32'h1);
        @(posedge clk);
        @(negedge clk);
        #1;
        chk("R10 fetch_pc high", fetch_pc, 32'hFFFF_FFF4);
        chk("R7 squashed word", ifid_ir, 32'h0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R10 next_pc wrap", next_pc, 32'h0);
        @(posedge clk);
        @(negedge clk);
        #1;
        chk("R10 fetch_pc wrapped", fetch_pc, 32'h0);

        finish_run();
    end
endmodule